// File: doc/BRIEF.md
# Event-Driven Convolution Integrator Array

This block turns a stream of pixel address events into a running two-dimensional convolution. Every accepted event names a row and a column of a 64 by 64 grid. The block adds a programmable square kernel of signed weights into the 8-bit integrator cells around that address, with the kernel centred on the event. The cells live in a dual-port RAM. One port belongs to the block's own read-modify-write engine. The other port lets a downstream consumer, such as a random output-event generator, read any cell at any moment.

A single adder serves the whole kernel, so each kernel weight costs one read cycle and one write cycle. Every cell saturates to the unsigned range 0 to 255. A forgetting timer with a programmable period, measured in cycles, requests a sweep that subtracts a programmable amount from every cell, stopping at zero. This keeps busy regions from sitting at full scale. Kernel weights, kernel size, forgetting period and forgetting amount are loaded through a plain write port.

The event input is a valid/ready stream. The source holds `ev_valid`, `ev_row` and `ev_col` steady until it sees a clock edge with `ev_ready` high, and an event is taken on that edge. `ev_ready` is low during the post-reset clear, while a kernel scatter runs, while a forgetting sweep runs, and while a sweep is pending. So back-pressure lasts exactly as long as the work in progress.

Top module: `evconv_array`

## Requirements
- R1: After reset, every cell is cleared to 0 before the first event is taken, and `ev_ready` stays low until that clear is done.
- R2: A configuration write with `cfg_sel`=0 stores the signed byte `cfg_data[7:0]` as kernel weight (row a, column b) at `cfg_addr` = a·11 + b, whatever the active size. The value -128 is stored as -127, and addresses of 121 or above are ignored. All weights reset to 0.
- R3: A write with `cfg_sel`=1 sets the half-width h from `cfg_data`, giving a (2h+1)×(2h+1) kernel. Values 1 to 5 are accepted, any other value leaves h unchanged, and h resets to 1.
- R4: An event at (i,j) adds weight (a,b) to cell (i+a−h, j+b−h) for every a and b in 0..2h. Positions whose row or column falls outside 0..63 are skipped and change no cell.
- R5: Each addition saturates: a result above 255 is stored as 255 and a result below 0 is stored as 0.
- R6: After an event is taken, `ev_ready` stays low for exactly 2·(2h+1)² cycles and then returns high, unless a sweep is pending.
- R7: Configuration writes are accepted only when no clear, scatter or sweep is in progress. A write made during a scatter changes neither that event nor later ones.
- R8: A write with `cfg_sel`=2 loads the period P from `cfg_data`, and a write with `cfg_sel`=3 loads the amount from `cfg_data[7:0]`. A nonzero P requests a sweep after P counted cycles, and P=0 disables the timer. A pending sweep waits for a running scatter to finish. The sweep subtracts the amount from every cell, clamping at 0, and takes 2 cycles per cell. With the timer idle, `ev_ready` falls P cycles after the period write and stays low for 2·4096+1 cycles.
- R9: The read port returns the cell at `rd_addr` = row·64 + column one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this edge |
| ev_row | input | 6 | Event row |
| ev_col | input | 6 | Event column |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 weight, 1 half-width, 2 period, 3 amount |
| cfg_addr | input | 7 | Kernel weight address a·11+b |
| cfg_data | input | 16 | Configuration value |
| rd_addr | input | 12 | Read port cell address |
| rd_data | output | 8 | Read port cell value |

## Verification
The bench builds the block with its default parameters: a 64 by 64 array, 8-bit cells and weights, a kernel store of 11 by 11 and a 16-bit period. Under these defaults the smallest, a middle and the largest kernel size can be exercised, together with events on every border and corner of the grid. The bench keeps its own model of all 4096 cells and compares the whole array through the read port after each scenario. A short forgetting period of 100 cycles lets a full sweep, with clamping at zero, run within the cycle budget.

// File: rtl/evconv_pkg.sv
package evconv_pkg;

  typedef enum logic [2:0] {
    ST_CLR  = 3'd0,
    ST_IDLE = 3'd1,
    ST_SRD  = 3'd2,
    ST_SWR  = 3'd3,
    ST_FRD  = 3'd4,
    ST_FWR  = 3'd5
  } evc_state_t;

  localparam logic [1:0] SEL_COEF   = 2'd0;
  localparam logic [1:0] SEL_HALF   = 2'd1;
  localparam logic [1:0] SEL_PERIOD = 2'd2;
  localparam logic [1:0] SEL_AMOUNT = 2'd3;

endpackage

// File: rtl/evconv_cellram.sv
module evconv_cellram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/evconv_kmem.sv
module evconv_kmem #(
  parameter int KMAX   = 11,
  parameter int COEF_W = 8,
  localparam int KDEPTH = KMAX * KMAX,
  localparam int KA_W   = $clog2(KDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [KA_W-1:0]   waddr,
  input  logic [COEF_W-1:0] wdata,
  input  logic [KA_W-1:0]   raddr,
  output logic [COEF_W-1:0] q
);
  localparam logic [COEF_W-1:0] MOST_NEG = {1'b1, {(COEF_W-1){1'b0}}};
  localparam logic [COEF_W-1:0] CLAMPED  = {1'b1, {(COEF_W-2){1'b0}}, 1'b1};

  logic [COEF_W-1:0] coef [KDEPTH];
  logic [COEF_W-1:0] wval;

  assign wval = (wdata == MOST_NEG) ? CLAMPED : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < KDEPTH; k++) coef[k] <= '0;
      q <= '0;
    end else begin
      if (we && (int'(waddr) < KDEPTH)) coef[waddr] <= wval;
      q <= (int'(raddr) < KDEPTH) ? coef[raddr] : '0;
    end
  end

  AST_COEF_NOT_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    q != MOST_NEG); // R2

endmodule

// File: rtl/evconv_forget_timer.sv
module evconv_forget_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_we,
  input  logic [PER_W-1:0] per_data,
  input  logic             hold,
  input  logic             start,
  output logic             pend
);
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
      pend  <= 1'b0;
    end else if (per_we) begin
      per_q <= per_data;
      cnt_q <= '0;
      pend  <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else if (!pend && !hold && (per_q != '0)) begin
      if (cnt_q == per_q - 1'b1) begin
        cnt_q <= '0;
        pend  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !start && !per_we |=> pend); // R8

endmodule

// File: rtl/evconv_ctrl.sv
module evconv_ctrl
  import evconv_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 6,
  parameter int CELL_W = 8,
  parameter int COEF_W = 8,
  parameter int KMAX   = 11,
  parameter int CFG_DW = 16,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int KA_W   = $clog2(KMAX * KMAX),
  localparam int HMAX   = (KMAX - 1) / 2,
  localparam int HW_W   = $clog2(HMAX + 1),
  localparam int KC_W   = $clog2(KMAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [COL_W-1:0]  ev_col,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_DW-1:0] cfg_data,
  output logic              kmem_we,
  output logic [KA_W-1:0]   kmem_raddr,
  input  logic [COEF_W-1:0] kmem_q,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [CELL_W-1:0] ram_wdata,
  input  logic [CELL_W-1:0] ram_q,
  input  logic              fg_pend,
  output logic              fg_start,
  output logic              fg_hold,
  output logic              per_we
);
  localparam int PRW = ROW_W + 2;
  localparam int PCW = COL_W + 2;
  localparam int SW  = CELL_W + 2;

  evc_state_t        st;
  logic [HW_W-1:0]   h_q;
  logic [KC_W-1:0]   kr_q, kc_q;
  logic [ROW_W-1:0]  er_q;
  logic [COL_W-1:0]  ec_q;
  logic [ADDR_W-1:0] ptr_q, tgt_q;
  logic              tgt_ok_q;
  logic [CELL_W-1:0] amt_q;

  logic              idle, cfg_ok, ev_go, k_last_col, k_last_row;
  logic [KC_W-1:0]   nlast;
  logic [PRW-1:0]    pos_r;
  logic [PCW-1:0]    pos_c;
  logic              pos_ok;
  logic [SW-1:0]     coef_x, sum;
  logic [CELL_W-1:0] sat_v, fg_v;

  assign idle     = (st == ST_IDLE);
  assign ev_ready = idle && !fg_pend;
  assign ev_go    = ev_valid && ev_ready;
  assign cfg_ok   = cfg_we && idle;
  assign kmem_we  = cfg_ok && (cfg_sel == SEL_COEF);
  assign per_we   = cfg_ok && (cfg_sel == SEL_PERIOD);
  assign fg_start = idle && fg_pend;
  assign fg_hold  = (st == ST_CLR) || (st == ST_FRD) || (st == ST_FWR);

  assign nlast      = KC_W'({h_q, 1'b0});
  assign k_last_col = (kc_q == nlast);
  assign k_last_row = (kr_q == nlast);

  // Target position of the current kernel element, centred on the event.
  assign pos_r  = PRW'(er_q) + PRW'(kr_q) - PRW'(h_q);
  assign pos_c  = PCW'(ec_q) + PCW'(kc_q) - PCW'(h_q);
  assign pos_ok = (pos_r[PRW-1:ROW_W] == 2'b00) && (pos_c[PCW-1:COL_W] == 2'b00);

  assign kmem_raddr = KA_W'(kr_q) * KA_W'(KMAX) + KA_W'(kc_q);

  // Saturating accumulate of one weight into one cell.
  assign coef_x = {{(SW-COEF_W){kmem_q[COEF_W-1]}}, kmem_q};
  assign sum    = {2'b00, ram_q} + coef_x;
  always_comb begin
    if (sum[SW-1])          sat_v = '0;
    else if (sum[CELL_W])   sat_v = '1;
    else                    sat_v = sum[CELL_W-1:0];
  end

  assign fg_v = (ram_q > amt_q) ? (ram_q - amt_q) : '0;

  always_comb begin
    ram_addr  = ptr_q;
    ram_we    = 1'b0;
    ram_wdata = '0;
    case (st)
      ST_CLR: begin
        ram_we = 1'b1;
      end
      ST_SRD: begin
        ram_addr = {pos_r[ROW_W-1:0], pos_c[COL_W-1:0]};
      end
      ST_SWR: begin
        ram_addr  = tgt_q;
        ram_we    = tgt_ok_q;
        ram_wdata = sat_v;
      end
      ST_FWR: begin
        ram_we    = 1'b1;
        ram_wdata = fg_v;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_CLR;
      h_q      <= HW_W'(1);
      kr_q     <= '0;
      kc_q     <= '0;
      er_q     <= '0;
      ec_q     <= '0;
      ptr_q    <= '0;
      tgt_q    <= '0;
      tgt_ok_q <= 1'b0;
      amt_q    <= '0;
    end else begin
      if (cfg_ok && (cfg_sel == SEL_HALF) &&
          (cfg_data >= CFG_DW'(1)) && (cfg_data <= CFG_DW'(HMAX)))
        h_q <= cfg_data[HW_W-1:0];
      if (cfg_ok && (cfg_sel == SEL_AMOUNT))
        amt_q <= cfg_data[CELL_W-1:0];

      case (st)
        ST_CLR: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == '1) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (fg_pend) begin
            ptr_q <= '0;
            st    <= ST_FRD;
          end else if (ev_go) begin
            er_q <= ev_row;
            ec_q <= ev_col;
            kr_q <= '0;
            kc_q <= '0;
            st   <= ST_SRD;
          end
        end
        ST_SRD: begin
          tgt_q    <= ram_addr;
          tgt_ok_q <= pos_ok;
          st       <= ST_SWR;
        end
        ST_SWR: begin
          if (k_last_col) begin
            kc_q <= '0;
            if (k_last_row) begin
              st <= ST_IDLE;
            end else begin
              kr_q <= kr_q + 1'b1;
              st   <= ST_SRD;
            end
          end else begin
            kc_q <= kc_q + 1'b1;
            st   <= ST_SRD;
          end
        end
        ST_FRD: st <= ST_FWR;
        ST_FWR: begin
          ptr_q <= ptr_q + 1'b1;
          st    <= (ptr_q == '1) ? ST_IDLE : ST_FRD;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> !ev_ready); // R6

  AST_SAT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWR) && !kmem_q[COEF_W-1] |-> ram_wdata >= ram_q); // R5

  AST_SAT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWR) && kmem_q[COEF_W-1] |-> ram_wdata <= ram_q); // R5

  AST_FORGET_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FWR) |-> ram_wdata <= ram_q); // R8

endmodule

// File: rtl/evconv_array.sv
module evconv_array #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 6,
  parameter int CELL_W = 8,
  parameter int COEF_W = 8,
  parameter int KMAX   = 11,
  parameter int PER_W  = 16,
  parameter int CFG_DW = 16,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int KA_W   = $clog2(KMAX * KMAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [COL_W-1:0]  ev_col,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [KA_W-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CELL_W-1:0] rd_data
);
  logic              kmem_we;
  logic [KA_W-1:0]   kmem_raddr;
  logic [COEF_W-1:0] kmem_q;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_we;
  logic [CELL_W-1:0] ram_wdata, ram_q;
  logic              fg_pend, fg_start, fg_hold, per_we;

  evconv_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CELL_W(CELL_W), .COEF_W(COEF_W),
    .KMAX(KMAX), .CFG_DW(CFG_DW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_row(ev_row), .ev_col(ev_col),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .kmem_we(kmem_we), .kmem_raddr(kmem_raddr), .kmem_q(kmem_q),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_q(ram_q),
    .fg_pend(fg_pend), .fg_start(fg_start), .fg_hold(fg_hold), .per_we(per_we)
  );

  evconv_kmem #(.KMAX(KMAX), .COEF_W(COEF_W)) u_kmem (
    .clk(clk), .rst_n(rst_n),
    .we(kmem_we), .waddr(cfg_addr), .wdata(cfg_data[COEF_W-1:0]),
    .raddr(kmem_raddr), .q(kmem_q)
  );

  evconv_forget_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_data(cfg_data[PER_W-1:0]),
    .hold(fg_hold), .start(fg_start), .pend(fg_pend)
  );

  evconv_cellram #(.ADDR_W(ADDR_W), .DATA_W(CELL_W)) u_cells (
    .clk(clk),
    .a_addr(ram_addr), .a_we(ram_we), .a_wdata(ram_wdata), .a_q(ram_q),
    .b_addr(rd_addr), .b_q(rd_data)
  );

endmodule

// File: tb/evconv_array_test.sv
`timescale 1ns/1ps
module evconv_array_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [5:0]  ev_row = '0, ev_col = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [6:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic [11:0] rd_addr = '0;
  logic [7:0]  rd_data;

  always #2 clk = ~clk;

  evconv_array uut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_row(ev_row), .ev_col(ev_col),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int model [4096];
  int kern [121];
  int hh = 1;
  int amt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void m_event(input int r, input int c);
    for (int a = 0; a <= 2*hh; a++)
      for (int b = 0; b <= 2*hh; b++) begin
        int pr, pc, v;
        pr = r + a - hh;
        pc = c + b - hh;
        if (pr >= 0 && pr < 64 && pc >= 0 && pc < 64) begin
          v = model[pr*64+pc] + kern[a*11+b];
          if (v > 255) v = 255;
          if (v < 0) v = 0;
          model[pr*64+pc] = v;
        end
      end
  endfunction

  task automatic cfg_write(input int sel, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 2'(sel);
    cfg_addr = 7'(addr);
    cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_coef(input int a, input int b, input int v);
    cfg_write(0, a*11+b, v);
    kern[a*11+b] = (v == -128) ? -127 : v;
  endtask

  // Offers one event, returns the number of cycles ready stays low after it is taken.
  task automatic send_event(input int r, input int c, input bit busy_cfg, output int lowcnt);
    bit s;
    @(negedge clk);
    ev_valid = 1'b1;
    ev_row = 6'(r);
    ev_col = 6'(c);
    forever begin
      s = ev_ready;
      @(negedge clk);
      if (s) break;
    end
    ev_valid = 1'b0;
    lowcnt = 0;
    while (!ev_ready) begin
      lowcnt++;
      if (busy_cfg && lowcnt == 1) begin
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_data = 16'd1;
      end else if (busy_cfg && lowcnt == 2) begin
        cfg_sel = 2'd0; cfg_addr = 7'd60; cfg_data = 16'd99;
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    m_event(r, c);
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    for (int k = 0; k <= 4096; k++) begin
      @(negedge clk);
      if (k > 0 && int'(rd_data) != model[k-1]) begin
        if (bad < 4)
          $display("FAIL %s: cell %0d actual %0d expected %0d", req, k-1, rd_data, model[k-1]);
        bad++;
      end
      if (k < 4096) rd_addr = 12'(k);
    end
    checks++;
    if (bad > 0) fails++;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ev_ready == 1'b0, "R1 ready low during clear", int'(ev_ready), 0);
    while (!ev_ready) @(negedge clk);
    compare_all("R1/R9 cleared array");
  endtask

  task automatic t_scatter3;
    int n;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) set_coef(a, b, (a*3 + b + 1) * 4);
    send_event(10, 20, 0, n);
    check(n == 18, "R6 3x3 event cycles", n, 18);
    compare_all("R4 3x3 scatter");
  endtask

  task automatic t_edge;
    int n;
    send_event(0, 0, 0, n);
    send_event(63, 63, 0, n);
    send_event(0, 63, 0, n);
    send_event(63, 0, 0, n);
    check(n == 18, "R6 corner event cycles", n, 18);
    compare_all("R4 border positions skipped");
  endtask

  task automatic t_sat;
    int n;
    set_coef(1, 1, 127);
    for (int k = 0; k < 3; k++) send_event(30, 30, 0, n);
    compare_all("R5 saturation at 255");
    set_coef(0, 0, -50);
    set_coef(1, 1, -128);
    send_event(30, 30, 0, n);
    compare_all("R2/R5 clamp -128 and floor at 0");
  endtask

  task automatic t_size;
    int n;
    cfg_write(1, 0, 2);
    hh = 2;
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) set_coef(a, b, (a*5 + b) % 9 - 2);
    send_event(40, 5, 0, n);
    check(n == 50, "R3/R6 5x5 event cycles", n, 50);
    send_event(2, 61, 0, n);
    cfg_write(1, 0, 5);
    hh = 5;
    for (int a = 0; a < 11; a++)
      for (int b = 0; b < 11; b++) set_coef(a, b, (a*7 + b*3) % 11 - 3);
    send_event(50, 50, 0, n);
    check(n == 242, "R3/R6 11x11 event cycles", n, 242);
    send_event(5, 58, 0, n);
    compare_all("R3/R4 larger kernels");
  endtask

  task automatic t_badsize;
    int n;
    cfg_write(1, 0, 6);
    cfg_write(1, 0, 0);
    cfg_write(0, 121, 55);
    send_event(20, 40, 0, n);
    check(n == 242, "R3 invalid half-width ignored", n, 242);
    compare_all("R2/R3 invalid writes ignored");
  endtask

  task automatic t_busy;
    int n;
    send_event(33, 12, 1, n);
    check(n == 242, "R7 busy config write ignored", n, 242);
    send_event(34, 13, 0, n);
    check(n == 242, "R7 size unchanged after busy write", n, 242);
    compare_all("R7 weights unchanged after busy write");
  endtask

  task automatic t_forget;
    int hi, lo;
    cfg_write(3, 0, 5);
    amt = 5;
    cfg_write(2, 0, 100);
    hi = 0;
    while (ev_ready && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
    check(hi == 100, "R8 sweep request delay", hi, 100);
    lo = 0;
    while (!ev_ready && lo < 20000) begin
      lo++;
      @(negedge clk);
    end
    check(lo == 8193, "R8 sweep duration", lo, 8193);
    cfg_write(2, 0, 0);
    for (int k = 0; k < 4096; k++) model[k] = (model[k] > amt) ? model[k] - amt : 0;
    compare_all("R8 forgetting sweep");
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) model[k] = 0;
    for (int k = 0; k < 121; k++) kern[k] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    t_scatter3;
    t_edge;
    t_sat;
    t_size;
    t_badsize;
    t_busy;
    t_forget;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule